// File: doc/BRIEF.md
# Predicated Result Writeback Gate

This block is the last step before the register file for vector element results. One element is presented per cycle. For that element the gate decides whether to write the computed value, write zero, or leave the destination untouched. It also decides whether to store the element's 4-bit condition field. The decision combines three things: the destination predicate bit, the zeroing option, and an optional test on the fresh result. When the test is enabled and fails, the element behaves exactly as if its predicate bit were clear. Even then, the condition field is still recorded when condition recording is on.

The gate derives the condition nibble from the result itself, using a signed comparison against zero. The summary-overflow flag is supplied by the caller. A 2-bit selector names which nibble bit the test looks at, and an invert flag chooses whether that bit must be set or clear. When condition recording is off, the test is a plain zero/nonzero check. A separate flag then makes the gate record the condition field while suppressing the result write. Every element is handled independently, and all outputs are registered once.

Top module: `pred_wb_gate`

## Requirements
- R1: All outputs are registered and appear one clock after the element is presented with `valid_i`=1. A cycle with `valid_i`=0 gives `res_we_o`=0 and `cr_we_o`=0 on the next cycle. Reset clears both enables.
- R2: The condition nibble is `{lt,gt,eq,so}`, with bit 3 = lt and bit 0 = so. The bits are: lt = result is negative as a signed value; gt = result is positive and nonzero; eq = result is zero; so = `so_i`.
- R3: When `mode_i` is not 2'b11, no test is made. Predicate 1 writes the result. Predicate 0 with `dz_i`=1 writes zero. Predicate 0 with `dz_i`=0 writes nothing.
- R4: When `mode_i`=2'b11 and `rc_i`=1, the tested bit is nibble bit (3 − `crsel_i`). That is, `crsel_i` values 0, 1, 2 and 3 select lt, gt, eq and so. The test passes when the tested bit XOR `inv_i` is 1.
- R5: When `mode_i`=2'b11 and `rc_i`=0, the tested bit is eq. The test passes when eq XOR `inv_i` is 1.
- R6: A failed test acts as predicate 0. With `dz_i`=1 zero is written; with `dz_i`=0 nothing is written.
- R7: With `rc_i`=1, every valid element whose predicate bit is 1 has its condition nibble written. This holds whatever the test outcome or mode.
- R8: With `mode_i`=2'b11, `rc_i`=0 and `rc1_i`=1, the condition nibble is written as in R7, and `res_we_o` stays 0.
- R9: An element whose predicate bit is 0 never writes its condition field, even when zeroing writes its result.
- R10: `idx_o` repeats the `idx_i` of the element that produced the current outputs.
- R11: With `rc_i`=0 and the R8 case not active, `cr_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Element present this cycle |
| result_i | input | DATA_W | Computed element result |
| so_i | input | 1 | Summary-overflow flag for the nibble |
| pred_i | input | 1 | Destination predicate bit |
| mode_i | input | 2 | 2'b11 enables the result test; other values give plain predication |
| rc_i | input | 1 | Condition recording enable |
| inv_i | input | 1 | Invert sense of the test |
| crsel_i | input | 2 | Nibble bit chosen for the test when `rc_i`=1 |
| dz_i | input | 1 | Write zero for masked elements |
| rc1_i | input | 1 | Record condition only, no result (test mode, `rc_i`=0) |
| idx_i | input | IDX_W | Element index |
| res_we_o | output | 1 | Result write enable |
| res_data_o | output | DATA_W | Result write data |
| cr_we_o | output | 1 | Condition field write enable |
| cr_data_o | output | 4 | Condition nibble |
| idx_o | output | IDX_W | Index of the element being written |

## Verification
The checker assumes that every input is stable and known at each rising edge while `valid_i` is high. It also assumes that each such edge carries a new, independent element. The bench meets both assumptions by changing inputs only on falling edges and by dropping `valid_i` after each element. The checker does not model `so_i` or the result value when it constrains the condition data. It only relates enables and zeroed data to the inputs sampled one cycle earlier. The bench therefore checks the nibble contents directly against hand-derived values.

// File: rtl/pred_wb_pkg.sv
package pred_wb_pkg;
  localparam int unsigned CR_W = 4;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_FFIRST = 2'b01,
    MODE_SAT    = 2'b10,
    MODE_PRED   = 2'b11
  } wb_mode_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_nib_t;
endpackage

// File: rtl/pwg_cond_gen.sv
module pwg_cond_gen
  import pred_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              so_i,
  output cr_nib_t           nib_o
);
  logic is_zero;
  assign is_zero  = ~|result_i;
  assign nib_o.lt = result_i[DATA_W-1];
  assign nib_o.gt = ~result_i[DATA_W-1] & ~is_zero;
  assign nib_o.eq = is_zero;
  assign nib_o.so = so_i;
endmodule

// File: rtl/pwg_cond_test.sv
module pwg_cond_test
  import pred_wb_pkg::*;
(
  input  cr_nib_t    nib_i,
  input  logic       rc_i,
  input  logic       inv_i,
  input  logic [1:0] crsel_i,
  output logic       pass_o
);
  logic [CR_W-1:0] nib_vec;
  logic [1:0]      pos;
  logic            tested;

  assign nib_vec = nib_i;
  assign pos     = 2'd3 - crsel_i;

  // Rc=0: zero/nonzero check on eq
  always_comb begin
    if (rc_i) tested = nib_vec[pos];
    else      tested = nib_i.eq;
  end

  assign pass_o = tested ^ inv_i;
endmodule

// File: rtl/pwg_wb_decide.sv
module pwg_wb_decide
  import pred_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              valid_i,
  input  wb_mode_e          mode_i,
  input  logic              pred_i,
  input  logic              dz_i,
  input  logic              rc_i,
  input  logic              rc1_i,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              res_we_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              cr_we_o
);
  logic test_en, rc1_act, eff_pred;

  assign test_en  = (mode_i == MODE_PRED);
  assign rc1_act  = test_en & ~rc_i & rc1_i;
  // failed test behaves as a cleared predicate bit
  assign eff_pred = pred_i & (~test_en | pass_i);

  assign res_we_o   = valid_i & ~rc1_act & (eff_pred | dz_i);
  assign res_data_o = eff_pred ? result_i : '0;
  assign cr_we_o    = valid_i & pred_i & (rc_i | rc1_act);
endmodule

// File: rtl/pred_wb_gate.sv
module pred_wb_gate
  import pred_wb_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              so_i,
  input  logic              pred_i,
  input  logic [1:0]        mode_i,
  input  logic              rc_i,
  input  logic              inv_i,
  input  logic [1:0]        crsel_i,
  input  logic              dz_i,
  input  logic              rc1_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              res_we_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              cr_we_o,
  output logic [CR_W-1:0]   cr_data_o,
  output logic [IDX_W-1:0]  idx_o
);
  cr_nib_t           nib;
  logic              pass;
  logic              res_we_d, cr_we_d;
  logic [DATA_W-1:0] res_data_d;
  wb_mode_e          mode;

  assign mode = wb_mode_e'(mode_i);

  pwg_cond_gen #(.DATA_W(DATA_W)) i_cond_gen (
    .result_i (result_i),
    .so_i     (so_i),
    .nib_o    (nib)
  );

  pwg_cond_test i_cond_test (
    .nib_i   (nib),
    .rc_i    (rc_i),
    .inv_i   (inv_i),
    .crsel_i (crsel_i),
    .pass_o  (pass)
  );

  pwg_wb_decide #(.DATA_W(DATA_W)) i_wb_decide (
    .valid_i    (valid_i),
    .mode_i     (mode),
    .pred_i     (pred_i),
    .dz_i       (dz_i),
    .rc_i       (rc_i),
    .rc1_i      (rc1_i),
    .pass_i     (pass),
    .result_i   (result_i),
    .res_we_o   (res_we_d),
    .res_data_o (res_data_d),
    .cr_we_o    (cr_we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_we_o   <= 1'b0;
      res_data_o <= '0;
      cr_we_o    <= 1'b0;
      cr_data_o  <= '0;
      idx_o      <= '0;
    end else begin
      res_we_o   <= res_we_d;
      res_data_o <= res_data_d;
      cr_we_o    <= cr_we_d;
      cr_data_o  <= nib;
      idx_o      <= idx_i;
    end
  end
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] result_i,
  input logic              pred_i,
  input logic [1:0]        mode_i,
  input logic              rc_i,
  input logic              rc1_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic              res_we_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              cr_we_o,
  input logic [IDX_W-1:0]  idx_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!res_we_o && !cr_we_o));

  p_plain_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 2'b11 && pred_i) |=> (res_we_o && res_data_o == $past(result_i)));

  p_rc_records_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rc_i && pred_i) |=> cr_we_o);

  p_rc1_no_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b11 && !rc_i && rc1_i) |=> !res_we_o);

  p_masked_no_cr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pred_i) |=> (!cr_we_o && (!res_we_o || res_data_o == '0)));

  p_idx_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (idx_o == $past(idx_i)));

  p_no_record_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rc_i && !(mode_i == 2'b11 && rc1_i)) |=> !cr_we_o);
endmodule

bind pred_wb_gate pwg_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_pwg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .result_i   (result_i),
  .pred_i     (pred_i),
  .mode_i     (mode_i),
  .rc_i       (rc_i),
  .rc1_i      (rc1_i),
  .idx_i      (idx_i),
  .res_we_o   (res_we_o),
  .res_data_o (res_data_o),
  .cr_we_o    (cr_we_o),
  .idx_o      (idx_o)
);

// File: tb/test_pred_wb_gate.sv
module test_pred_wb_gate;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned IDX_W  = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] result_i = '0;
  logic              so_i = 1'b0;
  logic              pred_i = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic              rc_i = 1'b0;
  logic              inv_i = 1'b0;
  logic [1:0]        crsel_i = 2'b00;
  logic              dz_i = 1'b0;
  logic              rc1_i = 1'b0;
  logic [IDX_W-1:0]  idx_i = '0;
  logic              res_we_o;
  logic [DATA_W-1:0] res_data_o;
  logic              cr_we_o;
  logic [3:0]        cr_data_o;
  logic [IDX_W-1:0]  idx_o;

  int checks = 0;
  int failures = 0;
  logic [IDX_W-1:0] next_idx = '0;

  always #4 clk_i = ~clk_i;

  pred_wb_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_pred_wb_gate (.*);

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one element, check outputs one cycle later
  task automatic elem(input string req, input logic [1:0] md, input logic rc, input logic inv,
                      input logic [1:0] sel, input logic pr, input logic dz, input logic r1,
                      input logic [DATA_W-1:0] res, input logic so,
                      input logic e_rwe, input logic [DATA_W-1:0] e_rdata,
                      input logic e_cwe, input logic [3:0] e_cdata);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = md; rc_i = rc; inv_i = inv; crsel_i = sel;
    pred_i = pr; dz_i = dz; rc1_i = r1; result_i = res; so_i = so; idx_i = next_idx;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " res_we"}, DATA_W'(res_we_o), DATA_W'(e_rwe));
    if (e_rwe) chk({req, " res_data"}, res_data_o, e_rdata);
    chk({req, " cr_we"}, DATA_W'(cr_we_o), DATA_W'(e_cwe));
    if (e_cwe) chk({req, " cr_data"}, DATA_W'(cr_data_o), DATA_W'(e_cdata));
    chk("R10 idx", DATA_W'(idx_o), DATA_W'(next_idx));
    next_idx = next_idx + 7'd5;
  endtask

  task automatic t_reset();
    chk("R1 reset res_we", DATA_W'(res_we_o), '0);
    chk("R1 reset cr_we", DATA_W'(cr_we_o), '0);
  endtask

  task automatic t_normal();
    elem("R3 pred1",        2'b00, 0, 0, 0, 1, 0, 0, 64'd5, 0, 1, 64'd5, 0, 4'h0);
    elem("R3 dz zero",      2'b00, 0, 0, 0, 0, 1, 0, 64'd9, 0, 1, 64'd0, 0, 4'h0);
    elem("R3 skip",         2'b00, 0, 0, 0, 0, 0, 0, 64'd9, 0, 0, 64'd0, 0, 4'h0);
    elem("R3 mode01 notest",2'b01, 0, 0, 0, 1, 0, 1, 64'd7, 0, 1, 64'd7, 0, 4'h0);
    elem("R11 rc0 no cr",   2'b10, 0, 1, 2, 1, 0, 0, 64'd3, 1, 1, 64'd3, 0, 4'h0);
  endtask

  task automatic t_nibble();
    elem("R2 neg so",  2'b00, 1, 0, 0, 1, 0, 0, -64'sd3, 1, 1, -64'sd3, 1, 4'b1001);
    elem("R2 zero",    2'b00, 1, 0, 0, 1, 0, 0, 64'd0,   0, 1, 64'd0,   1, 4'b0010);
    elem("R2 pos",     2'b00, 1, 0, 0, 1, 0, 0, 64'd12,  0, 1, 64'd12,  1, 4'b0100);
  endtask

  task automatic t_pred_rc1();
    elem("R4 gt pass",     2'b11, 1, 0, 1, 1, 0, 0, 64'd5,   0, 1, 64'd5,   1, 4'b0100);
    elem("R6 gt fail skip",2'b11, 1, 0, 1, 1, 0, 0, -64'sd3, 0, 0, 64'd0,   1, 4'b1000);
    elem("R6 gt fail dz",  2'b11, 1, 0, 1, 1, 1, 0, -64'sd3, 0, 1, 64'd0,   1, 4'b1000);
    elem("R4 inv pass",    2'b11, 1, 1, 1, 1, 0, 0, -64'sd3, 0, 1, -64'sd3, 1, 4'b1000);
    elem("R4 so pass",     2'b11, 1, 0, 3, 1, 0, 0, 64'd8,   1, 1, 64'd8,   1, 4'b0101);
    elem("R4 lt fail",     2'b11, 1, 0, 0, 1, 0, 0, 64'd8,   0, 0, 64'd0,   1, 4'b0100);
    elem("R7 eq fail cr",  2'b11, 1, 0, 2, 1, 0, 0, 64'd4,   0, 0, 64'd0,   1, 4'b0100);
  endtask

  task automatic t_pred_rc0();
    elem("R5 nonzero pass",2'b11, 0, 1, 0, 1, 0, 0, 64'd7, 0, 1, 64'd7, 0, 4'h0);
    elem("R5 zero fail",   2'b11, 0, 0, 0, 1, 0, 0, 64'd7, 0, 0, 64'd0, 0, 4'h0);
    elem("R6 fail dz",     2'b11, 0, 0, 0, 1, 1, 0, 64'd7, 0, 1, 64'd0, 0, 4'h0);
  endtask

  task automatic t_rc1opt();
    elem("R8 cr only",     2'b11, 0, 0, 0, 1, 0, 1, 64'd0, 1, 0, 64'd0, 1, 4'b0011);
    elem("R8 dz no write", 2'b11, 0, 0, 0, 1, 1, 1, 64'd6, 0, 0, 64'd0, 1, 4'b0100);
  endtask

  task automatic t_masked();
    elem("R9 dz no cr",    2'b11, 1, 0, 1, 0, 1, 0, 64'd5, 0, 1, 64'd0, 0, 4'h0);
    elem("R9 rc1 masked",  2'b11, 0, 0, 0, 0, 0, 1, 64'd5, 0, 0, 64'd0, 0, 4'h0);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    valid_i = 1'b0; pred_i = 1'b1; rc_i = 1'b1; dz_i = 1'b1;
    @(negedge clk_i);
    chk("R1 idle res_we", DATA_W'(res_we_o), '0);
    chk("R1 idle cr_we", DATA_W'(cr_we_o), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_normal();
    t_nibble();
    t_pred_rc1();
    t_pred_rc0();
    t_rc1opt();
    t_masked();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule